// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block answers a maskable interrupt with a fixed, locked acknowledge sequence on the bus. A request is taken only when an instruction-boundary enable is high with it. The sequencer then runs two acknowledge bus operations. Each one has a single status clock followed by a command phase that is stretched until `ready` is seen high. A fixed idle gap separates the two operations. The first operation only lets an external interrupt controller pick which cascaded controller answers, so data on that operation is discarded. The low byte of the data bus in the second operation is the interrupt vector.

For the whole sequence the bus is held locked. The sequencer's own address drivers stay released from the first status clock until after the first command clock of the second operation. The second operation always carries at least one forced wait clock after its `ready`, which gives the address drivers time to take the bus back without a clash. A hold request that arrives in the middle of a sequence is granted only once the sequence is over.

The captured vector leaves on a one-way stream: `vec_valid` is a single-clock pulse with `vec_data`, and there is no back-pressure. The consumer must take the byte in the pulse clock. `vec_data` then holds until the next capture.

Top module: `intack_seq`

## Requirements
- R1: While reset is applied and in the first clock after it, `inta_n`=1, `lock_n`=1, `addr_drive_en`=1, `hold_ack`=0 and `vec_valid`=0.
- R2: A sequence starts at a clock edge where the block is idle, `hold_ack` is 0 and `intr_req` and `boundary` are both 1. The next clock is the status clock of the first operation (`inta_n`=1, `lock_n`=0).
- R3: Each sequence has exactly two acknowledge operations. In each one a single status clock with `inta_n`=1 is followed by a command phase with `inta_n`=0, which lasts until an edge where `ready`=1. `ready` is ignored outside the command phases.
- R4: Between the end of the first command phase and the status clock of the second operation there are exactly 3 idle clocks with `inta_n`=1 and `lock_n`=0, whatever `ready` does.
- R5: After the edge where `ready`=1 ends the second command phase, `inta_n` stays 0 for exactly 1 more clock.
- R6: `lock_n` is 0 from the first status clock through the last clock of the second operation, and 1 in every idle clock.
- R7: `addr_drive_en` is 0 from the first status clock through the first command clock of the second operation, and 1 from the second command clock to the end. In idle it equals the inverse of `hold_ack`.
- R8: `vec_data` takes bits 7:0 of `data_in` at the edge where `ready`=1 in the second command phase. Data in the first operation and data after that edge are ignored. `vec_valid` is 1 for exactly the first idle clock after the sequence, and `vec_data` holds its value afterwards.
- R9: In idle, `hold_req`=1 with no start makes `hold_ack`=1 on the next clock. While `hold_ack`=1 no sequence starts and `addr_drive_en`=0. During a sequence `hold_ack` stays 0 and rises one clock after the sequence ends if `hold_req` is still 1.
- R10: When a start and `hold_req` fall on the same idle edge with `hold_ack`=0, the sequence starts and the hold is deferred.
- R11: `intr_req` without `boundary`, or `boundary` without `intr_req`, starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intr_req | input | 1 | Maskable interrupt request |
| boundary | input | 1 | Instruction-boundary enable for sampling the request |
| ready | input | 1 | Bus ready, ends a command phase |
| hold_req | input | 1 | Request from another master for the bus |
| data_in | input | 8 | Data bus, low byte carries the vector |
| inta_n | output | 1 | Acknowledge command strobe, active low |
| lock_n | output | 1 | Bus lock, active low |
| addr_drive_en | output | 1 | Enables the sequencer's address drivers |
| hold_ack | output | 1 | Bus granted to the other master |
| vec_valid | output | 1 | One-clock pulse, vector captured |
| vec_data | output | 8 | Captured interrupt vector |

## Verification
Two things can meet on one edge: the start of a sequence and a hold request. The bench drives `intr_req`, `boundary` and `hold_req` high in the same idle clock and expects the lock to fall on the next clock, with `hold_ack` kept at 0 through the whole sequence. The grant must then come only one clock after the vector pulse. A second case raises `hold_req` in the middle of the second command phase, and the same deferred grant is expected.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAT1,
    ST_CMD1,
    ST_GAP,
    ST_STAT2,
    ST_CMD2,
    ST_XWAIT
  } ack_state_t;
endpackage

// File: rtl/intack_fsm.sv
module intack_fsm
  import intack_pkg::*;
#(
  parameter int GAP_CLKS    = 3,
  parameter int EXTRA_WAITS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       intr_req,
  input  logic       boundary,
  input  logic       ready,
  input  logic       hold_ack,
  output ack_state_t state,
  output logic       start,
  output logic       a2_first,
  output logic       cap_en,
  output logic       seq_done
);
  localparam int CNT_MAX = (GAP_CLKS > EXTRA_WAITS) ? GAP_CLKS : EXTRA_WAITS;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CLKS - 1);
  localparam logic [CNT_W-1:0] XW_LAST  = CNT_W'(EXTRA_WAITS - 1);

  ack_state_t       nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign start    = (state == ST_IDLE) && intr_req && boundary && !hold_ack;
  assign cap_en   = (state == ST_CMD2) && ready;
  assign seq_done = (state == ST_XWAIT) && (cnt == XW_LAST);

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_STAT1;
      ST_STAT1: nxt = ST_CMD1;
      ST_CMD1:  if (ready) begin
                  nxt     = ST_GAP;
                  cnt_nxt = '0;
                end
      ST_GAP:   if (cnt == GAP_LAST) nxt = ST_STAT2;
                else cnt_nxt = cnt + 1'b1;
      ST_STAT2: nxt = ST_CMD2;
      ST_CMD2:  if (ready) begin
                  nxt     = ST_XWAIT;
                  cnt_nxt = '0;
                end
      ST_XWAIT: if (cnt == XW_LAST) nxt = ST_IDLE;
                else cnt_nxt = cnt + 1'b1;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      a2_first <= 1'b0;
    end else begin
      state    <= nxt;
      cnt      <= cnt_nxt;
      a2_first <= (state == ST_STAT2);
    end
  end
endmodule

// File: rtl/intack_vec_cap.sv
module intack_vec_cap #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             seq_done,
  input  logic [VEC_W-1:0] data_in,
  output logic [VEC_W-1:0] vec_data,
  output logic             vec_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_data  <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (cap_en) vec_data <= data_in;
      vec_valid <= seq_done;
    end
  end
endmodule

// File: rtl/intack_hold_arb.sv
module intack_hold_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic idle,
  input  logic start,
  output logic hold_ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_req && idle && !start;
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int GAP_CLKS    = 3,
  parameter int EXTRA_WAITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intr_req,
  input  logic             boundary,
  input  logic             ready,
  input  logic             hold_req,
  input  logic [VEC_W-1:0] data_in,
  output logic             inta_n,
  output logic             lock_n,
  output logic             addr_drive_en,
  output logic             hold_ack,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data
);
  ack_state_t state;
  logic start, a2_first, cap_en, seq_done, idle;

  assign idle = (state == ST_IDLE);

  intack_fsm #(.GAP_CLKS(GAP_CLKS), .EXTRA_WAITS(EXTRA_WAITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .boundary(boundary),
    .ready(ready), .hold_ack(hold_ack), .state(state), .start(start),
    .a2_first(a2_first), .cap_en(cap_en), .seq_done(seq_done)
  );

  intack_vec_cap #(.VEC_W(VEC_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .seq_done(seq_done),
    .data_in(data_in), .vec_data(vec_data), .vec_valid(vec_valid)
  );

  intack_hold_arb u_hold (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .idle(idle),
    .start(start), .hold_ack(hold_ack)
  );

  assign inta_n = !((state == ST_CMD1) || (state == ST_CMD2) || (state == ST_XWAIT));
  assign lock_n = idle;

  always_comb begin
    if (idle)                   addr_drive_en = !hold_ack;
    else if (state == ST_CMD2)  addr_drive_en = !a2_first;
    else                        addr_drive_en = (state == ST_XWAIT);
  end
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             intr_req,
  input logic             boundary,
  input logic             ready,
  input logic             hold_req,
  input logic [VEC_W-1:0] data_in,
  input logic             inta_n,
  input logic             lock_n,
  input logic             addr_drive_en,
  input logic             hold_ack,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_data
);
  // strobe only inside the locked window
  p_strobe_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n |-> !lock_n);
  // hold never granted while the bus is locked
  p_hold_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> lock_n);
  // granted bus means address drivers released
  p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !addr_drive_en);
  // vector pulse lasts one clock and appears in idle
  p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> lock_n);
  // qualified request in idle starts a sequence
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_n && !hold_ack && intr_req && boundary) |=> !lock_n);
  // no boundary, no start
  p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_n && !boundary) |=> lock_n);
endmodule

bind intack_seq intack_seq_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_intack_seq.sv
module sim_intack_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, intr_req, boundary, ready, hold_req;
  logic [7:0] data_in;
  logic       inta_n, lock_n, addr_drive_en, hold_ack, vec_valid;
  logic [7:0] vec_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intack_seq u0 (
    .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .boundary(boundary),
    .ready(ready), .hold_req(hold_req), .data_in(data_in),
    .inta_n(inta_n), .lock_n(lock_n), .addr_drive_en(addr_drive_en),
    .hold_ack(hold_ack), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus(string tag, logic e_inta, logic e_lock, logic e_addr);
    chk({tag, " R3 inta_n"}, 32'(inta_n), 32'(e_inta));
    chk({tag, " R6 lock_n"}, 32'(lock_n), 32'(e_lock));
    chk({tag, " R7 addr_drive_en"}, 32'(addr_drive_en), 32'(e_addr));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; intr_req = 0; boundary = 0; ready = 0; hold_req = 0; data_in = 8'h00;
    repeat (2) @(negedge clk);
    bus("R1 in reset", 1, 1, 1);
    rst_n = 1'b1;
    @(negedge clk);
    bus("R1 after reset", 1, 1, 1);
    chk("R1 hold_ack", 32'(hold_ack), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
  endtask

  // full sequence; w1/w2 extra command clocks before ready
  task automatic t_sequence(int w1, int w2, logic [7:0] d1, logic [7:0] d2,
                            bit hold_start, bit hold_mid);
    intr_req = 1; boundary = 1; ready = 0;
    if (hold_start) hold_req = 1;
    @(negedge clk);
    intr_req = 0; boundary = 0;
    bus("R2 stat1", 1, 0, 0);
    chk("R10 hold deferred", 32'(hold_ack), 0);
    ready = 1; data_in = d1;
    for (int j = 0; j <= w1; j++) begin
      @(negedge clk);
      bus("R3 cmd1", 0, 0, 0);
      data_in = d1; ready = (j == w1);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      bus("R4 gap", 1, 0, 0);
      chk("R9 hold_ack in seq", 32'(hold_ack), 0);
      ready = 1;
    end
    @(negedge clk);
    bus("R4 stat2", 1, 0, 0);
    ready = 1;
    for (int j = 0; j <= w2; j++) begin
      @(negedge clk);
      bus("R7 cmd2", 0, 0, (j == 0) ? 1'b0 : 1'b1);
      data_in = (j == w2) ? d2 : ~d2;
      ready = (j == w2);
      if (hold_mid) hold_req = 1;
    end
    @(negedge clk);
    bus("R5 extra wait", 0, 0, 1);
    chk("R9 hold_ack in seq", 32'(hold_ack), 0);
    data_in = ~d2; ready = 0;
    @(negedge clk);
    bus("R6 end idle", 1, 1, 1);
    chk("R8 vec_valid", 32'(vec_valid), 1);
    chk("R8 vec_data", 32'(vec_data), 32'(d2));
    chk("R9 hold_ack deferred", 32'(hold_ack), 0);
    @(negedge clk);
    chk("R8 vec_valid pulse", 32'(vec_valid), 0);
    chk("R8 vec_data held", 32'(vec_data), 32'(d2));
    chk("R9 hold_ack after seq", 32'(hold_ack), 32'(hold_start | hold_mid));
    chk("R7 addr with hold", 32'(addr_drive_en), 32'(!(hold_start | hold_mid)));
    hold_req = 0;
    @(negedge clk);
    chk("R9 hold released", 32'(hold_ack), 0);
  endtask

  task automatic t_no_boundary();
    intr_req = 1; boundary = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R11 intr without boundary", 32'(lock_n), 1);
    end
    intr_req = 0; boundary = 1;
    repeat (2) begin
      @(negedge clk);
      chk("R11 boundary without intr", 32'(lock_n), 1);
    end
    boundary = 0;
  endtask

  task automatic t_hold_idle();
    hold_req = 1;
    @(negedge clk);
    chk("R9 hold granted", 32'(hold_ack), 1);
    chk("R9 addr released", 32'(addr_drive_en), 0);
    intr_req = 1; boundary = 1;
    repeat (2) begin
      @(negedge clk);
      chk("R9 no start under hold", 32'(lock_n), 1);
      chk("R9 hold kept", 32'(hold_ack), 1);
    end
    intr_req = 0; boundary = 0; hold_req = 0;
    @(negedge clk);
    chk("R9 hold dropped", 32'(hold_ack), 0);
    chk("R7 idle addr", 32'(addr_drive_en), 1);
    chk("R9 still idle", 32'(lock_n), 1);
  endtask

  initial begin
    t_reset();
    t_sequence(0, 0, 8'h11, 8'h5A, 0, 0);
    t_sequence(2, 3, 8'hC3, 8'hA7, 0, 0);
    t_no_boundary();
    t_hold_idle();
    t_sequence(1, 0, 8'hFF, 8'h08, 1, 0);
    t_sequence(0, 2, 8'h00, 8'hE1, 0, 1);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule